// File: doc/BRIEF.md
# Banked Dual Data Pointer Unit

This block keeps two separate 16-bit data pointers for an 8-bit microcontroller core. Only one pointer can be seen at a time. Software reaches it through a fixed pair of byte registers in the special-function register space. Bit 0 of an 8-bit control register decides which pointer is visible. A copy loop can keep its source address in one pointer and its destination address in the other. Between the read and the write it flips the select bit, which it usually does by incrementing the control register.

The core drives byte-wide register accesses: an address, write data, a write strobe and combinational read data. It also drives three strobes. The first loads a full 16-bit value into the visible pointer, the second increments the visible pointer and the third increments the control register. The visible pointer is always present on a 16-bit address output that feeds the external data memory address path. Bits 7:1 of the control register are plain storage.

Top module: `dpb_top`

## Requirements
- R1: After a synchronous reset, both pointers and all 8 control bits are zero. `xaddr` is 0000h and a read of A2h returns 00h.
- R2: Register address 83h reaches the high byte and 84h reaches the low byte of the selected pointer only. Address A2h reads and writes all 8 control bits. A read of any other address returns 00h.
- R3: Control bit 0 is the select bit: 0 exposes pointer 0 and 1 exposes pointer 1, on reads, writes, loads, increments and `xaddr`.
- R4: A `ctl_inc` pulse inverts control bit 0 only. Bits 7:1 keep their values, so repeated pulses alternate between the pointers.
- R5: A `ptr_inc` pulse adds one to the full 16-bit selected pointer, carrying from the low byte into the high byte and wrapping FFFFh to 0000h. The unselected pointer never changes.
- R6: A `ptr_load` pulse writes `ptr_load_val` into the selected pointer only.
- R7: When several operations hit the same register in one cycle, a load beats a byte write, which beats an increment; the losing increment is dropped. A write to A2h beats `ctl_inc`.
- R8: `xaddr` and `sfr_rdata` are combinational from the stored state. Any pointer operation in a cycle where the select bit changes acts on the pointer that was selected before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Register write strobe |
| sfr_rdata | output | 8 | Register read data for `sfr_addr` |
| ptr_load | input | 1 | Load the selected pointer with `ptr_load_val` |
| ptr_load_val | input | 16 | 16-bit load value |
| ptr_inc | input | 1 | Increment the selected pointer |
| ctl_inc | input | 1 | Increment the control register (flips the select bit) |
| xaddr | output | 16 | Selected pointer, to the external memory address path |

## Verification
The hardest cases to reach from the ports are the collisions, in which a load, a byte write and an increment land in the same cycle while the select bit also changes. Without the R8 ordering rule those collisions would corrupt the wrong pointer. The bench drives all strobes at once with high probability from a fixed-seed random stream and compares each cycle with a bench model. Directed sequences force the FFFFh wrap, a carry out of the low byte, preserved upper control bits, and a write to A2h in the same cycle as `ctl_inc`.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
    localparam int PTR_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int NUM_PTR  = 2;
    localparam int SEL_W    = $clog2(NUM_PTR);

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HI   = 2'd1,
        TGT_LO   = 2'd2,
        TGT_CTL  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        logic wr_ctl;
    } wr_hits_t;

    function automatic tgt_e addr_to_tgt(byte_t a, byte_t hi_a, byte_t lo_a, byte_t ctl_a);
        if (a == hi_a)       return TGT_HI;
        else if (a == lo_a)  return TGT_LO;
        else if (a == ctl_a) return TGT_CTL;
        else                 return TGT_NONE;
    endfunction
endpackage

// File: rtl/dpb_decode.sv
module dpb_decode
    import dpb_pkg::*;
#(
    parameter byte_t HI_ADDR  = 8'h83,
    parameter byte_t LO_ADDR  = 8'h84,
    parameter byte_t CTL_ADDR = 8'hA2
) (
    input  byte_t    addr,
    input  logic     we,
    output tgt_e     tgt,
    output wr_hits_t hits
);
    always_comb begin
        tgt        = addr_to_tgt(addr, HI_ADDR, LO_ADDR, CTL_ADDR);
        hits.wr_hi  = we && (tgt == TGT_HI);
        hits.wr_lo  = we && (tgt == TGT_LO);
        hits.wr_ctl = we && (tgt == TGT_CTL);
    end
endmodule

// File: rtl/dpb_ctl_reg.sv
module dpb_ctl_reg
    import dpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    input  logic  inc,
    output byte_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (wr)   q <= wdata;
        else if (inc)  q <= {q[BYTE_W-1:1], ~q[0]};
    end
endmodule

// File: rtl/dpb_ptr_slot.sv
module dpb_ptr_slot
    import dpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  active,
    input  logic  load,
    input  ptr_t  load_val,
    input  logic  wr_hi,
    input  logic  wr_lo,
    input  byte_t wdata,
    input  logic  inc,
    output ptr_t  q
);
    localparam int HALF = PTR_W / 2;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (active) begin
            if (load)       q <= load_val;
            else if (wr_hi) q[PTR_W-1:HALF] <= wdata;
            else if (wr_lo) q[HALF-1:0] <= wdata;
            else if (inc)   q <= q + ptr_t'(1);
        end
    end
endmodule

// File: rtl/dpb_top.sv
module dpb_top
    import dpb_pkg::*;
#(
    parameter byte_t HI_ADDR  = 8'h83,
    parameter byte_t LO_ADDR  = 8'h84,
    parameter byte_t CTL_ADDR = 8'hA2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  sfr_addr,
    input  logic [7:0]  sfr_wdata,
    input  logic        sfr_we,
    output logic [7:0]  sfr_rdata,
    input  logic        ptr_load,
    input  logic [15:0] ptr_load_val,
    input  logic        ptr_inc,
    input  logic        ctl_inc,
    output logic [15:0] xaddr
);
    localparam int HALF = PTR_W / 2;

    tgt_e                      tgt;
    wr_hits_t                  hits;
    byte_t                     aux_q;
    logic [SEL_W-1:0]          sel;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
    ptr_t                      cur;

    dpb_decode #(
        .HI_ADDR(HI_ADDR), .LO_ADDR(LO_ADDR), .CTL_ADDR(CTL_ADDR)
    ) i_decode (
        .addr(sfr_addr), .we(sfr_we), .tgt(tgt), .hits(hits)
    );

    dpb_ctl_reg i_ctl (
        .clk(clk), .rst(rst), .wr(hits.wr_ctl), .wdata(sfr_wdata),
        .inc(ctl_inc), .q(aux_q)
    );

    assign sel = aux_q[SEL_W-1:0];

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
        dpb_ptr_slot i_slot (
            .clk(clk), .rst(rst),
            .active(sel == SEL_W'(g)),
            .load(ptr_load), .load_val(ptr_load_val),
            .wr_hi(hits.wr_hi), .wr_lo(hits.wr_lo), .wdata(sfr_wdata),
            .inc(ptr_inc), .q(ptr_q[g])
        );
    end

    assign cur   = ptr_q[sel];
    assign xaddr = cur;

    always_comb begin
        unique case (tgt)
            TGT_HI:  sfr_rdata = cur[PTR_W-1:HALF];
            TGT_LO:  sfr_rdata = cur[HALF-1:0];
            TGT_CTL: sfr_rdata = aux_q;
            default: sfr_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dpb_chk.sv
module dpb_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  sfr_addr,
    input logic [7:0]  sfr_wdata,
    input logic        sfr_we,
    input logic        ptr_load,
    input logic        ptr_inc,
    input logic        ctl_inc,
    input logic [15:0] xaddr,
    input logic [7:0]  aux_q,
    input logic [15:0] p0,
    input logic [15:0] p1
);
    logic ctl_wr, byte_wr;
    assign ctl_wr  = sfr_we && (sfr_addr == 8'hA2);
    assign byte_wr = sfr_we && ((sfr_addr == 8'h83) || (sfr_addr == 8'h84));

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (xaddr == 16'h0 && aux_q == 8'h0 && p0 == 16'h0 && p1 == 16'h0));

    assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_inc && !ctl_wr) |=> (aux_q == {$past(aux_q[7:1]), ~$past(aux_q[0])}));

    assert_incr_R5: assert property (@(posedge clk) disable iff (rst)
        (ptr_inc && !ptr_load && !byte_wr && !aux_q[0]) |=> (p0 == $past(xaddr) + 16'd1));

    assert_keep_p1_R5: assert property (@(posedge clk) disable iff (rst)
        (aux_q[0] == 1'b0) |=> $stable(p1));

    assert_keep_p0_R6: assert property (@(posedge clk) disable iff (rst)
        (aux_q[0] == 1'b1) |=> $stable(p0));

    assert_ctl_prio_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_inc) |=> (aux_q == $past(sfr_wdata)));
endmodule

bind dpb_top dpb_chk i_chk (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .ptr_load(ptr_load), .ptr_inc(ptr_inc),
    .ctl_inc(ctl_inc), .xaddr(xaddr), .aux_q(aux_q),
    .p0(ptr_q[0]), .p1(ptr_q[1])
);

// File: tb/test_dpb_top.sv
module test_dpb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic        sfr_we, ptr_load, ptr_inc, ctl_inc;
    logic [15:0] ptr_load_val, xaddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] m_ptr [2];
    logic [7:0]  m_aux;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpb_top i_dpb_top (
        .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .ptr_load(ptr_load),
        .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc), .ctl_inc(ctl_inc),
        .xaddr(xaddr)
    );

    function automatic logic [7:0] exp_rdata(logic [7:0] a);
        logic [15:0] c = m_ptr[m_aux[0]];
        case (a)
            8'h83:   return c[15:8];
            8'h84:   return c[7:0];
            8'hA2:   return m_aux;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        int s = m_aux[0];
        if (ptr_load)                          m_ptr[s] = ptr_load_val;
        else if (sfr_we && sfr_addr == 8'h83)  m_ptr[s][15:8] = sfr_wdata;
        else if (sfr_we && sfr_addr == 8'h84)  m_ptr[s][7:0] = sfr_wdata;
        else if (ptr_inc)                      m_ptr[s] = m_ptr[s] + 16'd1;
        if (sfr_we && sfr_addr == 8'hA2)       m_aux = sfr_wdata;
        else if (ctl_inc)                      m_aux[0] = ~m_aux[0];
    endtask

    // drive at negedge, check combinational read, clock, check xaddr
    task automatic cyc(string req, logic [7:0] a, logic [7:0] wd, logic we,
                       logic ld, logic [15:0] lv, logic pi, logic ci);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = wd; sfr_we = we;
        ptr_load = ld; ptr_load_val = lv; ptr_inc = pi; ctl_inc = ci;
        #1;
        check({req, " R2 rdata"}, 32'(sfr_rdata), 32'(exp_rdata(a)));
        @(posedge clk);
        model_step();
        #1;
        check({req, " R8 xaddr"}, 32'(xaddr), 32'(m_ptr[m_aux[0]]));
    endtask

    task automatic idle();
        cyc("idle", 8'h00, 8'h00, 0, 0, 16'h0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        sfr_addr = 0; sfr_wdata = 0; sfr_we = 0; ptr_load = 0;
        ptr_load_val = 0; ptr_inc = 0; ctl_inc = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        m_ptr[0] = 0; m_ptr[1] = 0; m_aux = 0;
        // R1 reset state
        check("R1 xaddr", 32'(xaddr), 0);
        sfr_addr = 8'hA2; #1;
        check("R1 ctl", 32'(sfr_rdata), 0);

        // R6/R3: load each pointer, select by bit 0
        cyc("R6 load p0", 8'h00, 0, 0, 1, 16'h1234, 0, 0);
        cyc("R4 flip", 8'h00, 0, 0, 0, 16'h0, 0, 1);
        check("R3 sel1 xaddr", 32'(xaddr), 0);
        cyc("R6 load p1", 8'h00, 0, 0, 1, 16'hBEEF, 0, 0);
        cyc("R4 flip back", 8'hA2, 0, 0, 0, 16'h0, 0, 1);
        check("R3 sel0 xaddr", 32'(xaddr), 32'h1234);

        // R5 carry out of the low byte and full wrap
        cyc("R5 setlo", 8'h84, 8'hFF, 1, 0, 16'h0, 0, 0);
        cyc("R5 carry", 8'h83, 0, 0, 0, 16'h0, 1, 0);
        check("R5 carry", 32'(xaddr), 32'h1300);
        cyc("R5 ldmax", 8'h00, 0, 0, 1, 16'hFFFF, 0, 0);
        cyc("R5 wrap", 8'h00, 0, 0, 0, 16'h0, 1, 0);
        check("R5 wrap", 32'(xaddr), 32'h0000);
        cyc("R5 other", 8'h00, 0, 0, 0, 16'h0, 0, 1);
        check("R5 other intact", 32'(xaddr), 32'hBEEF);

        // R4 upper control bits kept across ctl_inc
        cyc("R2 ctl wr", 8'hA2, 8'hA6, 1, 0, 16'h0, 0, 0);
        cyc("R4 inc", 8'hA2, 0, 0, 0, 16'h0, 0, 1);
        cyc("R4 read", 8'hA2, 0, 0, 0, 16'h0, 0, 0);
        check("R4 upper kept", 32'(m_aux), 32'hA7);
        cyc("R4 inc2", 8'hA2, 0, 0, 0, 16'h0, 0, 1);
        check("R4 carry dropped", 32'(m_aux), 32'hA6);

        // R7 priorities
        cyc("R7 ctl wr beats inc", 8'hA2, 8'h10, 1, 0, 16'h0, 0, 1);
        cyc("R7 byte beats inc", 8'h83, 8'h55, 1, 0, 16'h0, 1, 0);
        check("R7 byte beats inc", 32'(xaddr), 32'h5500);
        cyc("R7 load beats byte", 8'h84, 8'h77, 1, 1, 16'hC0DE, 1, 0);
        check("R7 load wins", 32'(xaddr), 32'hC0DE);
        // R8 op with simultaneous select change hits old pointer
        cyc("R8 old sel", 8'h00, 0, 0, 0, 16'h0, 1, 1);
        check("R8 p0 incr", 32'(m_ptr[0]), 32'hC0DF);
        // R2 unmapped read
        cyc("R2 unmapped", 8'h82, 0, 0, 0, 16'h0, 0, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int r = $urandom_range(0, 4);
            a = (r == 0) ? 8'h83 : (r == 1) ? 8'h84 : (r == 2) ? 8'hA2 : 8'($urandom);
            cyc("rand R3 R5 R6 R7", a, 8'($urandom), 1'($urandom_range(0, 2) == 0),
                1'($urandom_range(0, 5) == 0), 16'($urandom),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 2) == 0));
        end

        // R1 reset again mid-run
        @(negedge clk); rst = 1;
        @(posedge clk); #1; rst = 0;
        m_ptr[0] = 0; m_ptr[1] = 0; m_aux = 0;
        check("R1 re-reset xaddr", 32'(xaddr), 0);
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule